// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a narrow port (A, 12 bits by default) and a wide port (B) made of two narrow-width halves, all on a single clock. Going from A to B, two narrow words arriving on consecutive cycles are captured and then presented side by side as one wide word. The lower half passes through two pipeline stages and the upper half through one, so the earlier word lines up with the later one. Going from B to A, each half of the wide port is stored in its own register, and a registered select picks which stored half is driven onto the narrow port.

Every storage register has its own active-low load enable. The half select and both active-low output enables are sampled on the rising clock edge, so a change of direction takes effect only on an edge. Each port is split into separate input-data, output-data and output-enable signals, and a tristate pad wrapper outside the block uses them. A synchronous active-high reset clears all data registers to zero and puts both output enables into the disabled state.

Top module: `bus_exchanger`

## Requirements
- R1: After a synchronous reset, all data outputs read zero and both output-enable outputs are low (pads released).
- R2: When `lo_load_n` is low on an edge, the lower-half pipeline shifts: its first stage takes `a_in`, and `b_lo_out` takes what the first stage held before the edge. A word therefore appears on `b_lo_out` two loading edges after it was presented.
- R3: When `hi_load_n` is low on an edge, `b_hi_out` takes `a_in` on that edge.
- R4: If A word N is loaded with `lo_load_n` low and word N+1 with both loads low on the next edge, then after that edge `b_lo_out` holds N and `b_hi_out` holds N+1.
- R5: While `lo_load_n` and `hi_load_n` are both high, `b_lo_out` and `b_hi_out` keep their values whatever `a_in` does.
- R6: Each wide-port half `b_lo_in` / `b_hi_in` is stored on an edge where its own enable (`blo_load_n` / `bhi_load_n`) is low. Otherwise it is held.
- R7: `sel_hi` is registered. When the registered value is 1, `a_out` shows the stored `b_lo_in` word. When it is 0, `a_out` shows the stored `b_hi_in` word.
- R8: `a_oe` is the inverse of `oe_a_n` as sampled on the previous edge. `b_oe` is the inverse of `oe_b_n` as sampled on the previous edge. Both may be high together.
- R9: A change on `sel_hi`, `oe_a_n` or `oe_b_n` between edges has no effect on any output until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_a_n | input | 1 | Active-low narrow-port output-enable request |
| oe_b_n | input | 1 | Active-low wide-port output-enable request |
| lo_load_n | input | 1 | Active-low enable, A-to-lower-half pipeline |
| hi_load_n | input | 1 | Active-low enable, A-to-upper-half register |
| blo_load_n | input | 1 | Active-low enable, lower-half-to-A register |
| bhi_load_n | input | 1 | Active-low enable, upper-half-to-A register |
| sel_hi | input | 1 | Half select for A, 1 = lower half |
| a_in | input | NARROW_W | Narrow port input data |
| a_out | output | NARROW_W | Narrow port output data |
| a_oe | output | 1 | Narrow port pad drive enable, active high |
| b_lo_in | input | NARROW_W | Wide port lower-half input data |
| b_hi_in | input | NARROW_W | Wide port upper-half input data |
| b_lo_out | output | NARROW_W | Wide port lower-half output data |
| b_hi_out | output | NARROW_W | Wide port upper-half output data |
| b_oe | output | 1 | Wide port pad drive enable, active high |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge after reset. They also assume that reset is held for at least one edge before any check matters, because the history checks look back only one cycle and are disabled while reset is high. The bench drives all inputs on the falling clock edge so they are stable at every rising edge, and it holds reset over two edges before any stimulus. Where a scenario toggles inputs in the middle of a cycle, it does so only between the falling and the next rising edge, so no input changes near a sampling edge.

// File: rtl/bus_exchanger_pkg.sv
package bus_exchanger_pkg;
   localparam int unsigned DEF_NARROW_W = 12;
   localparam int unsigned DEF_LO_STAGES = 2;

   typedef struct packed {
      logic a_drive;
      logic b_drive;
      logic pick_lo;
   } ctl_state_t;
endpackage

// File: rtl/bx_stage_reg.sv
module bx_stage_reg #(
   parameter int unsigned W = 12,
   parameter int unsigned STAGES = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned LAST = STAGES - 1;

   initial begin
      assert (W > 0) else $error("W must be positive");
      assert (STAGES > 0) else $error("STAGES must be positive");
   end

   logic [W-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) pipe[s] <= '0;
               else if (!load_n) pipe[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) pipe[s] <= '0;
               else if (!load_n) pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[LAST];

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      load_n |=> $stable(q)); // R5
endmodule

// File: rtl/bx_ctl_reg.sv
module bx_ctl_reg
   import bus_exchanger_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       oe_a_n,
   input  logic       oe_b_n,
   input  logic       sel_hi,
   output ctl_state_t ctl
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ctl <= '{a_drive: 1'b0, b_drive: 1'b0, pick_lo: 1'b0};
      end else begin
         ctl.a_drive <= ~oe_a_n;
         ctl.b_drive <= ~oe_b_n;
         ctl.pick_lo <= sel_hi;
      end
   end

   AST_A_OE_REG: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ctl.a_drive == !$past(oe_a_n))); // R8
   AST_B_OE_REG: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ctl.b_drive == !$past(oe_b_n))); // R8
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
   import bus_exchanger_pkg::*;
#(
   parameter int unsigned NARROW_W  = DEF_NARROW_W,
   parameter int unsigned LO_STAGES = DEF_LO_STAGES
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                oe_a_n,
   input  logic                oe_b_n,
   input  logic                lo_load_n,
   input  logic                hi_load_n,
   input  logic                blo_load_n,
   input  logic                bhi_load_n,
   input  logic                sel_hi,
   input  logic [NARROW_W-1:0] a_in,
   output logic [NARROW_W-1:0] a_out,
   output logic                a_oe,
   input  logic [NARROW_W-1:0] b_lo_in,
   input  logic [NARROW_W-1:0] b_hi_in,
   output logic [NARROW_W-1:0] b_lo_out,
   output logic [NARROW_W-1:0] b_hi_out,
   output logic                b_oe
);
   localparam int unsigned HI_STAGES = LO_STAGES - 1;

   initial begin
      assert (LO_STAGES >= 2) else $error("lower path needs at least two stages");
   end

   ctl_state_t ctl;
   logic [NARROW_W-1:0] blo_q, bhi_q;

   bx_ctl_reg i_ctl (
      .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .sel_hi(sel_hi), .ctl(ctl)
   );

   bx_stage_reg #(.W(NARROW_W), .STAGES(LO_STAGES)) i_a2lo (
      .clk(clk), .rst(rst), .load_n(lo_load_n), .d(a_in), .q(b_lo_out)
   );
   bx_stage_reg #(.W(NARROW_W), .STAGES(HI_STAGES)) i_a2hi (
      .clk(clk), .rst(rst), .load_n(hi_load_n), .d(a_in), .q(b_hi_out)
   );
   bx_stage_reg #(.W(NARROW_W), .STAGES(1)) i_lo2a (
      .clk(clk), .rst(rst), .load_n(blo_load_n), .d(b_lo_in), .q(blo_q)
   );
   bx_stage_reg #(.W(NARROW_W), .STAGES(1)) i_hi2a (
      .clk(clk), .rst(rst), .load_n(bhi_load_n), .d(b_hi_in), .q(bhi_q)
   );

   assign a_out = ctl.pick_lo ? blo_q : bhi_q;
   assign a_oe  = ctl.a_drive;
   assign b_oe  = ctl.b_drive;

   AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      !hi_load_n |=> (b_hi_out == $past(a_in))); // R3
   AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      !blo_load_n |=> (blo_q == $past(b_lo_in))); // R6
   AST_SEL_PICK: assert property (@(posedge clk) disable iff (rst)
      (sel_hi && blo_load_n) |=> (a_out == $past(blo_q))); // R7
endmodule

// File: tb/test_bus_exchanger.sv
module test_bus_exchanger;
   localparam int W = 12;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 0, rst = 1;
   logic oe_a_n = 1, oe_b_n = 1, lo_load_n = 1, hi_load_n = 1;
   logic blo_load_n = 1, bhi_load_n = 1, sel_hi = 0;
   logic [W-1:0] a_in = '0, b_lo_in = '0, b_hi_in = '0;
   logic [W-1:0] a_out, b_lo_out, b_hi_out;
   logic a_oe, b_oe;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_exchanger #(.NARROW_W(W)) i_bus_exchanger (
      .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .lo_load_n(lo_load_n), .hi_load_n(hi_load_n),
      .blo_load_n(blo_load_n), .bhi_load_n(bhi_load_n), .sel_hi(sel_hi),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_lo_in(b_lo_in), .b_hi_in(b_hi_in),
      .b_lo_out(b_lo_out), .b_hi_out(b_hi_out), .b_oe(b_oe)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // inputs change at negedge; after the next posedge we sample at the following negedge
   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic idle();
      lo_load_n = 1; hi_load_n = 1; blo_load_n = 1; bhi_load_n = 1;
   endtask

   task automatic t_reset();
      chk("R1 b_lo", b_lo_out, 0); chk("R1 b_hi", b_hi_out, 0);
      chk("R1 a_out", a_out, 0);
      chk("R1 a_oe", {11'b0, a_oe}, 0); chk("R1 b_oe", {11'b0, b_oe}, 0);
   endtask

   task automatic t_pipe();
      idle(); lo_load_n = 0; a_in = 12'h111; step();
      chk("R2 first edge", b_lo_out, 0);
      a_in = 12'h222; step();
      chk("R2 second edge", b_lo_out, 12'h111);
   endtask

   task automatic t_pair();
      idle(); lo_load_n = 0; a_in = 12'hA5A; step();
      hi_load_n = 0; a_in = 12'h5C3; step();
      chk("R4 lo", b_lo_out, 12'hA5A); chk("R4 hi", b_hi_out, 12'h5C3);
      chk("R3 hi", b_hi_out, 12'h5C3);
   endtask

   task automatic t_hold();
      idle(); a_in = 12'hFFF; step(); a_in = 12'h0F0; step();
      chk("R5 lo hold", b_lo_out, 12'hA5A); chk("R5 hi hold", b_hi_out, 12'h5C3);
   endtask

   task automatic t_b2a();
      idle(); oe_a_n = 0;
      b_lo_in = 12'h3C1; b_hi_in = 12'h7E2; blo_load_n = 0; bhi_load_n = 0; sel_hi = 1; step();
      chk("R7 lower picked", a_out, 12'h3C1);
      sel_hi = 0; step();
      chk("R7 upper picked", a_out, 12'h7E2);
      idle(); b_hi_in = 12'h999; step();
      chk("R6 upper held", a_out, 12'h7E2);
      bhi_load_n = 0; step();
      chk("R6 upper loaded", a_out, 12'h999);
      idle(); blo_load_n = 0; b_lo_in = 12'h444; step();
      idle(); sel_hi = 1; step();
      chk("R6 lower loaded", a_out, 12'h444);
   endtask

   task automatic t_oe();
      oe_a_n = 0; oe_b_n = 0; step();
      chk("R8 both on a", {11'b0, a_oe}, 1); chk("R8 both on b", {11'b0, b_oe}, 1);
      oe_b_n = 1; step();
      chk("R8 b off", {11'b0, b_oe}, 0); chk("R8 a stays", {11'b0, a_oe}, 1);
   endtask

   task automatic t_sync();
      oe_a_n = 1; sel_hi = 0; #1;
      chk("R9 a_oe before edge", {11'b0, a_oe}, 1);
      chk("R9 sel before edge", a_out, 12'h444);
      step();
      chk("R9 a_oe after edge", {11'b0, a_oe}, 0);
      chk("R9 sel after edge", a_out, 12'h999);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 0;
      t_reset(); t_pipe(); t_pair(); t_hold(); t_b2a(); t_oe(); t_sync();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule